// File: doc/BRIEF.md
# Integer Condition Code Evaluator

This block decides whether a conditional branch, conditional trap or conditional move should take effect. It is purely combinational. In flag mode it receives two sets of integer condition flags, one computed from the low 32 bits of a result and one from the full 64-bit result. A select input picks one of the two sets, and a 4-bit condition code names the predicate to test against that set. The single output bit reports whether the predicate holds.

In register mode no flags are used. The block derives a sign bit and a zero bit straight from a 64-bit register value and evaluates one of six register tests, chosen by a 3-bit code. The two codes in that space that name no test raise an illegal-condition output, and the taken bit is then held low. The flag-producing ALU, target calculation, prediction hints and delay-slot annulment all live outside this block.

Top module: `icc_eval`

## Requirements
- R1: Each flag bus is packed as bit 3 N, bit 2 Z, bit 1 V, bit 0 C. With `useWide`=1 the predicate is tested on `flags64`; with `useWide`=0 it is tested on `flags32`. The set that is not selected has no effect on `taken`.
- R2: In flag mode, condition code 0 is never taken and code 8 is always taken, whatever the flags.
- R3: In flag mode, code 1 is taken when Z=1, and code 9 is taken when Z=0.
- R4: Signed codes in flag mode: code 2 is taken when Z or (N xor V); code 3 when N xor V; code 10 when not (Z or (N xor V)); code 11 when not (N xor V).
- R5: Unsigned codes in flag mode: code 4 is taken when C or Z, and code 12 when not (C or Z).
- R6: Single-flag codes in flag mode: code 5 tests C, code 6 tests N and code 7 tests V. Codes 13, 14 and 15 are their complements.
- R7: In register mode, N is bit 63 of `regValue` and Z means all 64 bits are zero. `regCond` selects the test: 1 is Z, 2 is N or Z, 3 is N, 5 is not Z, 6 is not (N or Z), and 7 is not N.
- R8: In register mode, `regCond` values 0 and 4 drive `illegalCond`=1 and `taken`=0. Every other `regCond` value drives `illegalCond`=0.
- R9: In register mode, `flags32`, `flags64`, `useWide` and `condCode` have no effect. In flag mode, `regValue` and `regCond` have no effect, and `illegalCond` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flags32 | input | 4 | N,Z,V,C flags of the 32-bit result (bit 3 down to bit 0) |
| flags64 | input | 4 | N,Z,V,C flags of the 64-bit result (bit 3 down to bit 0) |
| useWide | input | 1 | 1 selects flags64, 0 selects flags32 |
| condCode | input | 4 | Flag-mode predicate code |
| regMode | input | 1 | 1 selects the register-contents test |
| regCond | input | 3 | Register-mode predicate code |
| regValue | input | 64 | Register operand for register mode |
| taken | output | 1 | Predicate result |
| illegalCond | output | 1 | Reserved register-mode code was given |

## Verification
Two functions meet in the same evaluation: the flag predicate path and the register-contents path. Both are always driven, and only the mode bit separates them. The bench drives random, unrelated values onto both sets of inputs together in every vector. Each result is judged against a reference model that looks only at the inputs of the active mode. Reserved register codes are mixed in with busy flag inputs. This confirms that the illegal indication forces the result low no matter what the inactive flag path would have produced.

// File: rtl/icc_eval_pkg.sv
package icc_eval_pkg;

  localparam int FLAG_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

  typedef enum logic [3:0] {
    TERM_NEVER  = 4'd0,
    TERM_Z      = 4'd1,
    TERM_LE     = 4'd2,
    TERM_LT     = 4'd3,
    TERM_LEU    = 4'd4,
    TERM_C      = 4'd5,
    TERM_N      = 4'd6,
    TERM_V      = 4'd7,
    TERM_REG_Z  = 4'd8,
    TERM_REG_LEZ = 4'd9,
    TERM_REG_N  = 4'd10,
    TERM_NONE   = 4'd11
  } term_e;

  typedef struct packed {
    logic  selWide;
    logic  useReg;
    logic  invert;
    logic  illegal;
    term_e term;
  } evalCtrl_t;

endpackage

// File: rtl/icc_eval_ctrl.sv
module icc_eval_ctrl
  import icc_eval_pkg::*;
#(
  parameter int CC_W = 4,
  parameter int RC_W = 3
) (
  input  logic [CC_W-1:0] condCode,
  input  logic [RC_W-1:0] regCond,
  input  logic            regMode,
  input  logic            useWide,
  output evalCtrl_t       ctrl
);

  localparam int CC_SEL_W = CC_W - 1;
  localparam int RC_SEL_W = RC_W - 1;

  logic [CC_SEL_W-1:0] ccSel;
  logic [RC_SEL_W-1:0] rcSel;

  assign ccSel = condCode[CC_SEL_W-1:0];
  assign rcSel = regCond[RC_SEL_W-1:0];

  always_comb begin
    ctrl         = '0;
    ctrl.term    = TERM_NONE;
    ctrl.useReg  = regMode;
    ctrl.selWide = useWide;
    if (regMode) begin
      // upper code bit inverts the base register test
      ctrl.invert = regCond[RC_W-1];
      case (rcSel)
        2'd1:    ctrl.term = TERM_REG_Z;
        2'd2:    ctrl.term = TERM_REG_LEZ;
        2'd3:    ctrl.term = TERM_REG_N;
        default: begin
          ctrl.term    = TERM_NONE;
          ctrl.illegal = 1'b1;
        end
      endcase
    end else begin
      // upper code bit selects the complementary predicate
      ctrl.invert = condCode[CC_W-1];
      case (ccSel)
        3'd0:    ctrl.term = TERM_NEVER;
        3'd1:    ctrl.term = TERM_Z;
        3'd2:    ctrl.term = TERM_LE;
        3'd3:    ctrl.term = TERM_LT;
        3'd4:    ctrl.term = TERM_LEU;
        3'd5:    ctrl.term = TERM_C;
        3'd6:    ctrl.term = TERM_N;
        default: ctrl.term = TERM_V;
      endcase
    end
  end

endmodule

// File: rtl/icc_eval_dp.sv
module icc_eval_dp
  import icc_eval_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  evalCtrl_t         ctrl,
  input  logic [FLAG_W-1:0] flags32,
  input  logic [FLAG_W-1:0] flags64,
  input  logic [DATA_W-1:0] regValue,
  output logic              taken,
  output logic              illegalCond
);

  localparam int SIGN_BIT = DATA_W - 1;

  nzvc_t flagSel;
  logic  regN;
  logic  regZ;
  logic  baseTerm;
  logic  signedLt;

  assign flagSel  = ctrl.selWide ? nzvc_t'(flags64) : nzvc_t'(flags32);
  assign regN     = regValue[SIGN_BIT];
  assign regZ     = ~|regValue;
  assign signedLt = flagSel.n ^ flagSel.v;

  always_comb begin
    case (ctrl.term)
      TERM_NEVER:   baseTerm = 1'b0;
      TERM_Z:       baseTerm = flagSel.z;
      TERM_LE:      baseTerm = flagSel.z | signedLt;
      TERM_LT:      baseTerm = signedLt;
      TERM_LEU:     baseTerm = flagSel.c | flagSel.z;
      TERM_C:       baseTerm = flagSel.c;
      TERM_N:       baseTerm = flagSel.n;
      TERM_V:       baseTerm = flagSel.v;
      TERM_REG_Z:   baseTerm = regZ;
      TERM_REG_LEZ: baseTerm = regN | regZ;
      TERM_REG_N:   baseTerm = regN;
      default:      baseTerm = 1'b0;
    endcase
  end

  assign illegalCond = ctrl.useReg & ctrl.illegal;
  assign taken       = ~illegalCond & (baseTerm ^ ctrl.invert);

endmodule

// File: rtl/icc_eval.sv
module icc_eval
  import icc_eval_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CC_W   = 4,
  parameter int RC_W   = 3
) (
  input  logic [3:0]        flags32,
  input  logic [3:0]        flags64,
  input  logic              useWide,
  input  logic [CC_W-1:0]   condCode,
  input  logic              regMode,
  input  logic [RC_W-1:0]   regCond,
  input  logic [DATA_W-1:0] regValue,
  output logic              taken,
  output logic              illegalCond
);

  evalCtrl_t ctrl;

  icc_eval_ctrl #(.CC_W(CC_W), .RC_W(RC_W)) u_ctrl (
    .condCode (condCode),
    .regCond  (regCond),
    .regMode  (regMode),
    .useWide  (useWide),
    .ctrl     (ctrl)
  );

  icc_eval_dp #(.DATA_W(DATA_W)) u_dp (
    .ctrl        (ctrl),
    .flags32     (flags32),
    .flags64     (flags64),
    .regValue    (regValue),
    .taken       (taken),
    .illegalCond (illegalCond)
  );

endmodule

// File: rtl/icc_eval_chk.sv
module icc_eval_chk #(
  parameter int DATA_W = 64,
  parameter int CC_W   = 4,
  parameter int RC_W   = 3
) (
  input logic [3:0]        flags32,
  input logic [3:0]        flags64,
  input logic              useWide,
  input logic [CC_W-1:0]   condCode,
  input logic              regMode,
  input logic [RC_W-1:0]   regCond,
  input logic [DATA_W-1:0] regValue,
  input logic              taken,
  input logic              illegalCond
);

  logic [3:0] selFlags;
  logic       known;

  assign selFlags = useWide ? flags64 : flags32;
  assign known = !$isunknown({flags32, flags64, useWide, condCode, regMode,
                              regCond, regValue, taken, illegalCond});

  always_comb begin
    if (known) begin
      // R2
      never_taken_chk: assert (regMode || condCode != 4'd0 || !taken);
      // R2
      always_taken_chk: assert (regMode || condCode != 4'd8 || taken);
      // R3
      equal_follows_z_chk: assert (regMode || condCode != 4'd1 || taken == selFlags[2]);
      // R8
      illegal_blocks_taken_chk: assert (!illegalCond || !taken);
      // R8
      illegal_code_chk: assert (!regMode || illegalCond == (regCond[1:0] == 2'd0));
      // R9
      flag_mode_legal_chk: assert (regMode || !illegalCond);
      // R7
      zero_reg_chk: assert (!regMode || regValue != '0 || illegalCond ||
                            taken == (regCond == 3'd1 || regCond == 3'd2 || regCond == 3'd7));
    end
  end

endmodule

bind icc_eval icc_eval_chk #(.DATA_W(DATA_W), .CC_W(CC_W), .RC_W(RC_W)) u_chk (
  .flags32     (flags32),
  .flags64     (flags64),
  .useWide     (useWide),
  .condCode    (condCode),
  .regMode     (regMode),
  .regCond     (regCond),
  .regValue    (regValue),
  .taken       (taken),
  .illegalCond (illegalCond)
);

// File: tb/icc_eval_test.sv
`timescale 1ns/1ps
module icc_eval_test;

  logic        clk = 1'b0;
  logic [3:0]  flags32, flags64;
  logic        useWide, regMode;
  logic [3:0]  condCode;
  logic [2:0]  regCond;
  logic [63:0] regValue;
  logic        taken, illegalCond;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  icc_eval uut (
    .flags32(flags32), .flags64(flags64), .useWide(useWide),
    .condCode(condCode), .regMode(regMode), .regCond(regCond),
    .regValue(regValue), .taken(taken), .illegalCond(illegalCond)
  );

  function automatic bit refFlag(input logic [3:0] f, input logic [3:0] cc);
    bit n, z, v, c, b;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (cc[2:0])
      3'd0: b = 1'b0;
      3'd1: b = z;
      3'd2: b = z | (n ^ v);
      3'd3: b = n ^ v;
      3'd4: b = c | z;
      3'd5: b = c;
      3'd6: b = n;
      default: b = v;
    endcase
    return cc[3] ? !b : b;
  endfunction

  function automatic bit refReg(input logic [63:0] val, input logic [2:0] rc);
    bit n, z;
    n = val[63]; z = (val == 64'd0);
    case (rc)
      3'd1: return z;
      3'd2: return n | z;
      3'd3: return n;
      3'd5: return !z;
      3'd6: return !(n | z);
      3'd7: return !n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string reqOfFlag(input logic [3:0] cc);
    case (cc[2:0])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic checkBit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] f32, input logic [3:0] f64, input logic w,
                       input logic [3:0] cc, input logic rm, input logic [2:0] rc,
                       input logic [63:0] val, input string req);
    bit expT, expI;
    @(posedge clk);
    flags32 = f32; flags64 = f64; useWide = w; condCode = cc;
    regMode = rm; regCond = rc; regValue = val;
    @(negedge clk);
    if (rm) begin
      expI = (rc[1:0] == 2'd0);
      expT = refReg(val, rc);
    end else begin
      expI = 1'b0;
      expT = refFlag(w ? f64 : f32, cc);
    end
    checkBit(req, "taken", taken, expT);
    checkBit(expI ? "R8" : "R9", "illegalCond", illegalCond, expI);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    flags32 = '0; flags64 = '0; useWide = 0; condCode = '0;
    regMode = 0; regCond = '0; regValue = '0;
    // reset-like idle state: code 0 in flag mode
    apply(4'h0, 4'h0, 0, 4'd0, 0, 3'd0, 64'd0, "R2");
    apply(4'hF, 4'hF, 1, 4'd0, 0, 3'd0, 64'd0, "R2");
    apply(4'h0, 4'h0, 0, 4'd8, 0, 3'd0, 64'd0, "R2");
    // R1: opposite flag sets, only the selected one matters
    apply(4'b0100, 4'b0000, 0, 4'd1, 0, 3'd0, 64'd0, "R1");
    apply(4'b0100, 4'b0000, 1, 4'd1, 0, 3'd0, 64'd0, "R1");
    apply(4'b0000, 4'b0001, 1, 4'd5, 0, 3'd0, 64'd0, "R1");
    apply(4'b0000, 4'b0001, 0, 4'd5, 0, 3'd0, 64'd0, "R1");
    // R3 not equal
    apply(4'b0000, 4'b0100, 0, 4'd9, 0, 3'd0, 64'd0, "R3");
    // R4 N=1,V=1 is not less; N=1,V=0 is less
    apply(4'b1010, 4'h0, 0, 4'd3, 0, 3'd0, 64'd0, "R4");
    apply(4'b1000, 4'h0, 0, 4'd11, 0, 3'd0, 64'd0, "R4");
    apply(4'b0000, 4'h0, 0, 4'd10, 0, 3'd0, 64'd0, "R4");
    // R5
    apply(4'b0001, 4'h0, 0, 4'd12, 0, 3'd0, 64'd0, "R5");
    apply(4'b0000, 4'h0, 0, 4'd12, 0, 3'd0, 64'd0, "R5");
    // R6
    apply(4'b0010, 4'h0, 0, 4'd15, 0, 3'd0, 64'd0, "R6");
    apply(4'b1000, 4'h0, 0, 4'd14, 0, 3'd0, 64'd0, "R6");
    // R7 register boundaries
    for (int rc = 1; rc < 8; rc++) begin
      if (rc == 4) continue;
      apply(4'hF, 4'hF, 1, 4'd8, 1, 3'(rc), 64'd0, "R7");
      apply(4'h0, 4'h0, 0, 4'd0, 1, 3'(rc), 64'h8000_0000_0000_0000, "R7");
      apply(4'h0, 4'h0, 0, 4'd8, 1, 3'(rc), 64'h0000_0000_0000_0001, "R7");
      apply(4'h0, 4'h0, 0, 4'd8, 1, 3'(rc), 64'h0000_0001_0000_0000, "R7");
    end
    // R8 reserved codes with busy flag inputs
    apply(4'hF, 4'hF, 1, 4'd8, 1, 3'd0, 64'd0, "R8");
    apply(4'hF, 4'hF, 0, 4'd8, 1, 3'd4, 64'h8000_0000_0000_0000, "R8");
    // R9 flag mode ignores register inputs
    apply(4'h0, 4'h0, 0, 4'd1, 0, 3'd1, 64'd0, "R9");
    // mixed random vectors
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] val;
      logic [3:0] cc;
      logic rm;
      case ($urandom_range(0, 3))
        0: val = 64'd0;
        1: val = {$urandom(), $urandom()} | 64'h8000_0000_0000_0000;
        2: val = 64'($urandom_range(1, 15));
        default: val = {$urandom(), $urandom()};
      endcase
      cc = 4'($urandom());
      rm = 1'($urandom());
      apply(4'($urandom()), 4'($urandom()), 1'($urandom()), cc, rm,
            3'($urandom()), val, rm ? "R7" : reqOfFlag(cc));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule